// File: doc/BRIEF.md
# Page-Extended DMA Bus Address Former

This block builds the full system bus address for a set of DMA channels. A channel engine elsewhere owns each channel's 16-bit address counter. On every transfer it presents the current counter value, the channel number and the counting direction. The block joins that counter with a per-channel page register and returns a registered bus address with byte-lane enables one cycle later.

The page registers are separate latches loaded only from a host write port. DMA traffic never carries into them or borrows from them. A transfer therefore stays inside its page: when the counter rolls over, the bus address wraps within the same window. The block raises a flag on the request whose counter value would roll over in the stated direction, so the engine can react.

Channels below a configurable index are byte wide. Their counter lands on the low 16 address bits, and one byte lane is enabled. Channels at or above that index are word wide. Their counter is shifted up by one so it steps through even addresses, both lanes are enabled, and the lowest page bit is dropped. One channel is reserved for cascading and has no page register. With the default 8-bit pages the bus address is 24 bits wide; with 4-bit pages it is 20 bits.

Top module: `dma_page_addr`

## Requirements
- R1: After reset every output is zero and every page register holds zero, so a request on any channel yields page bits of zero.
- R2: A request presented with req_vld high produces bus_vld high on the next cycle, with the address, enables and flag for that request. A cycle with req_vld low produces bus_vld, bus_addr, bus_be and bus_wrap all zero on the next cycle.
- R3: For byte channels 0 to 3, bus_addr equals {page[7:0], cnt[15:0]}.
- R4: For word channels 5 to 7, bus_addr equals {page[7:1], cnt[15:0], 1'b0}, and bus_be is 2'b11.
- R5: For byte channels, bus_be is 2'b01 when address bit 0 is 0 and 2'b10 when it is 1.
- R6: A host write with wr_en high loads wr_data into the page register of channel wr_ch. A request in the same cycle on that channel still sees the old page; requests from the next cycle on see the new one.
- R7: Writes to channel 4 are ignored. A request on channel 4 uses word mapping with page bits zero.
- R8: bus_wrap is 1 exactly when the request counts up (req_dec=0) with cnt 16'hFFFF, or counts down (req_dec=1) with cnt 16'h0000. The page bits of the address are unaffected by the wrap.
- R9: A write to one channel leaves every other channel's page register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_vld | input | 1 | Address request valid |
| req_ch | input | 3 | Requesting channel |
| req_cnt | input | 16 | Channel's current address counter |
| req_dec | input | 1 | Counting direction: 1 down, 0 up |
| wr_en | input | 1 | Host page register write strobe |
| wr_ch | input | 3 | Channel whose page register is written |
| wr_data | input | 8 | New page value |
| bus_vld | output | 1 | Registered address valid |
| bus_addr | output | 24 | Full bus address |
| bus_be | output | 2 | Byte-lane enables, bit 1 upper lane |
| bus_wrap | output | 1 | Request would roll over the counter within its page |

## Verification
The bench drives counter values at both ends of the range in both directions. A design that let a carry reach the page bits would show a changed page on those requests. A design that decoded the flag from the wrong direction would raise it on FFFF when counting down.

It issues a host write and a request to the same channel in the same cycle. A design that bypassed the write would return the new page one cycle early.

It writes the cascade channel and pages of word channels with bit 0 set. A design that kept a register on channel 4, or that mapped the low page bit onto a word address, would show non-zero or shifted page bits.

Random traffic, biased toward counter extremes and mixed with writes, also covers lane selection and cross-channel isolation.

// File: rtl/dma_pg_pkg.sv
package dma_pg_pkg;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    typedef enum logic [1:0] {
        LANE_NONE = 2'b00,
        LANE_LOW  = 2'b01,
        LANE_HIGH = 2'b10,
        LANE_BOTH = 2'b11
    } lane_e;

endpackage

// File: rtl/dma_pg_regfile.sv
module dma_pg_regfile #(
    parameter int NUM_CH     = 8,
    parameter int PAGE_W     = 8,
    parameter int CASCADE_CH = 4,
    localparam int CH_W      = $clog2(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [CH_W-1:0]          wr_ch,
    input  logic [PAGE_W-1:0]        wr_data,
    output logic [NUM_CH*PAGE_W-1:0] pages
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        if (i == CASCADE_CH) begin : g_none
            assign pages[i*PAGE_W +: PAGE_W] = '0;
        end else begin : g_reg
            logic [PAGE_W-1:0] pg_d;
            logic [PAGE_W-1:0] pg_q;

            always_comb begin
                pg_d = pg_q;
                if (wr_en && (wr_ch == CH_W'(i))) begin
                    pg_d = wr_data;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    pg_q <= '0;
                end else begin
                    pg_q <= pg_d;
                end
            end

            assign pages[i*PAGE_W +: PAGE_W] = pg_q;
        end
    end

endmodule

// File: rtl/dma_pg_wrap.sv
module dma_pg_wrap
    import dma_pg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt,
    input  dir_e             dir,
    output logic             wrap
);

    logic at_top;
    logic at_bottom;

    always_comb begin
        at_top    = &cnt;
        at_bottom = ~|cnt;
        unique case (dir)
            DIR_UP:   wrap = at_top;
            DIR_DOWN: wrap = at_bottom;
            default:  wrap = 1'b0;
        endcase
    end

endmodule

// File: rtl/dma_pg_map.sv
module dma_pg_map
    import dma_pg_pkg::*;
#(
    parameter int CNT_W         = 16,
    parameter int PAGE_W        = 8,
    parameter int NUM_CH        = 8,
    parameter int WORD_CH_FIRST = 4,
    localparam int CH_W         = $clog2(NUM_CH),
    localparam int ADDR_W       = CNT_W + PAGE_W
) (
    input  logic [CH_W-1:0]   ch,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [PAGE_W-1:0] page,
    output logic [ADDR_W-1:0] addr,
    output lane_e             lanes
);

    logic              is_word;
    logic [ADDR_W-1:0] byte_addr;
    logic [ADDR_W-1:0] word_addr;

    always_comb begin
        is_word   = (ch >= CH_W'(WORD_CH_FIRST));
        byte_addr = {page, cnt};
        word_addr = {page[PAGE_W-1:1], cnt, 1'b0};
        if (is_word) begin
            addr  = word_addr;
            lanes = LANE_BOTH;
        end else begin
            addr  = byte_addr;
            lanes = byte_addr[0] ? LANE_HIGH : LANE_LOW;
        end
    end

endmodule

// File: rtl/dma_page_addr.sv
module dma_page_addr
    import dma_pg_pkg::*;
#(
    parameter int NUM_CH        = 8,
    parameter int CNT_W         = 16,
    parameter int PAGE_W        = 8,
    parameter int WORD_CH_FIRST = 4,
    parameter int CASCADE_CH    = 4,
    localparam int CH_W         = $clog2(NUM_CH),
    localparam int ADDR_W       = CNT_W + PAGE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_vld,
    input  logic [CH_W-1:0]   req_ch,
    input  logic [CNT_W-1:0]  req_cnt,
    input  logic              req_dec,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic [PAGE_W-1:0] wr_data,
    output logic              bus_vld,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_be,
    output logic              bus_wrap
);

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        lane_e             lanes;
        logic              wrap;
    } out_t;

    logic [NUM_CH*PAGE_W-1:0] pages;
    logic [PAGE_W-1:0]        sel_page;
    logic [ADDR_W-1:0]        map_addr;
    lane_e                    map_lanes;
    logic                     map_wrap;
    dir_e                     dir;
    out_t                     out_d;
    out_t                     out_q;

    dma_pg_regfile #(
        .NUM_CH     (NUM_CH),
        .PAGE_W     (PAGE_W),
        .CASCADE_CH (CASCADE_CH)
    ) u_regfile (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_ch   (wr_ch),
        .wr_data (wr_data),
        .pages   (pages)
    );

    assign sel_page = pages[req_ch*PAGE_W +: PAGE_W];
    assign dir      = req_dec ? DIR_DOWN : DIR_UP;

    dma_pg_map #(
        .CNT_W         (CNT_W),
        .PAGE_W        (PAGE_W),
        .NUM_CH        (NUM_CH),
        .WORD_CH_FIRST (WORD_CH_FIRST)
    ) u_map (
        .ch    (req_ch),
        .cnt   (req_cnt),
        .page  (sel_page),
        .addr  (map_addr),
        .lanes (map_lanes)
    );

    dma_pg_wrap #(
        .CNT_W (CNT_W)
    ) u_wrap (
        .cnt  (req_cnt),
        .dir  (dir),
        .wrap (map_wrap)
    );

    always_comb begin
        out_d = '0;
        if (req_vld) begin
            out_d.vld   = 1'b1;
            out_d.addr  = map_addr;
            out_d.lanes = map_lanes;
            out_d.wrap  = map_wrap;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign bus_vld  = out_q.vld;
    assign bus_addr = out_q.addr;
    assign bus_be   = out_q.lanes;
    assign bus_wrap = out_q.wrap;

endmodule

// File: rtl/dma_pg_chk.sv
module dma_pg_chk #(
    parameter int NUM_CH        = 8,
    parameter int CNT_W         = 16,
    parameter int PAGE_W        = 8,
    parameter int WORD_CH_FIRST = 4,
    parameter int CASCADE_CH    = 4,
    localparam int CH_W         = $clog2(NUM_CH),
    localparam int ADDR_W       = CNT_W + PAGE_W
) (
    input logic              clk,
    input logic              rst,
    input logic              req_vld,
    input logic [CH_W-1:0]   req_ch,
    input logic [CNT_W-1:0]  req_cnt,
    input logic              req_dec,
    input logic              bus_vld,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_be,
    input logic              bus_wrap
);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) req_vld |=> bus_vld); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !bus_vld |-> (bus_addr == '0 && bus_be == 2'b00 && !bus_wrap)); // R2

    AST_BYTE_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
        (bus_vld && $past(req_ch) < CH_W'(WORD_CH_FIRST))
        |-> bus_addr[CNT_W-1:0] == $past(req_cnt)); // R3

    AST_WORD_EVEN: assert property (@(posedge clk) disable iff (rst)
        (bus_vld && $past(req_ch) >= CH_W'(WORD_CH_FIRST))
        |-> (!bus_addr[0] && bus_be == 2'b11 && bus_addr[CNT_W:1] == $past(req_cnt))); // R4

    AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (rst)
        (bus_vld && $past(req_ch) < CH_W'(WORD_CH_FIRST))
        |-> ($countones(bus_be) == 1 && bus_be[1] == bus_addr[0])); // R5

    AST_CASCADE_NO_PAGE: assert property (@(posedge clk) disable iff (rst)
        (bus_vld && $past(req_ch) == CH_W'(CASCADE_CH))
        |-> bus_addr[ADDR_W-1:CNT_W+1] == '0); // R7

    AST_WRAP_EDGE: assert property (@(posedge clk) disable iff (rst)
        bus_vld |-> (bus_wrap == ($past(req_dec) ? ($past(req_cnt) == '0)
                                                 : ($past(req_cnt) == '1)))); // R8

endmodule

bind dma_page_addr dma_pg_chk #(
    .NUM_CH        (NUM_CH),
    .CNT_W         (CNT_W),
    .PAGE_W        (PAGE_W),
    .WORD_CH_FIRST (WORD_CH_FIRST),
    .CASCADE_CH    (CASCADE_CH)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_vld  (req_vld),
    .req_ch   (req_ch),
    .req_cnt  (req_cnt),
    .req_dec  (req_dec),
    .bus_vld  (bus_vld),
    .bus_addr (bus_addr),
    .bus_be   (bus_be),
    .bus_wrap (bus_wrap)
);

// File: tb/dma_page_addr_bench.sv
module dma_page_addr_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_vld = 1'b0;
    logic [2:0]  req_ch = '0;
    logic [15:0] req_cnt = '0;
    logic        req_dec = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_ch = '0;
    logic [7:0]  wr_data = '0;
    logic        bus_vld;
    logic [23:0] bus_addr;
    logic [1:0]  bus_be;
    logic        bus_wrap;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [7:0]  mpage [8];
    logic        e_vld;
    logic [23:0] e_addr;
    logic [1:0]  e_be;
    logic        e_wrap;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_page_addr u_dma_page_addr (
        .clk      (clk),
        .rst      (rst),
        .req_vld  (req_vld),
        .req_ch   (req_ch),
        .req_cnt  (req_cnt),
        .req_dec  (req_dec),
        .wr_en    (wr_en),
        .wr_ch    (wr_ch),
        .wr_data  (wr_data),
        .bus_vld  (bus_vld),
        .bus_addr (bus_addr),
        .bus_be   (bus_be),
        .bus_wrap (bus_wrap)
    );

    function automatic logic [23:0] ref_addr(input logic [2:0] ch, input logic [15:0] cnt,
                                             input logic [7:0] pg);
        if (ch >= 3'd4) return {pg[7:1], cnt, 1'b0};
        return {pg, cnt};
    endfunction

    function automatic logic [1:0] ref_be(input logic [2:0] ch, input logic [15:0] cnt);
        if (ch >= 3'd4) return 2'b11;
        return cnt[0] ? 2'b10 : 2'b01;
    endfunction

    function automatic logic ref_wrap(input logic [15:0] cnt, input logic dec);
        return dec ? (cnt == 16'h0000) : (cnt == 16'hFFFF);
    endfunction

    task automatic check_out(input string tag);
        total++;
        if (bus_vld !== e_vld || bus_addr !== e_addr || bus_be !== e_be || bus_wrap !== e_wrap) begin
            bad++;
            $display("FAIL %s: got vld=%0b addr=%06h be=%02b wrap=%0b expected vld=%0b addr=%06h be=%02b wrap=%0b",
                     tag, bus_vld, bus_addr, bus_be, bus_wrap, e_vld, e_addr, e_be, e_wrap);
        end
    endtask

    // Called at a falling edge; drives one cycle and checks the result at the next falling edge.
    task automatic cycle(input logic v, input logic [2:0] ch, input logic [15:0] cnt, input logic dec,
                         input logic we, input logic [2:0] wch, input logic [7:0] wd, input string tag);
        req_vld = v; req_ch = ch; req_cnt = cnt; req_dec = dec;
        wr_en = we; wr_ch = wch; wr_data = wd;
        e_vld  = v;
        e_addr = v ? ref_addr(ch, cnt, (ch == 3'd4) ? 8'h00 : mpage[ch]) : 24'h0;
        e_be   = v ? ref_be(ch, cnt) : 2'b00;
        e_wrap = v ? ref_wrap(cnt, dec) : 1'b0;
        if (we && wch != 3'd4) mpage[wch] = wd;
        @(negedge clk);
        check_out(tag);
    endtask

    task automatic idle(input string tag);
        cycle(1'b0, 3'd0, 16'h0, 1'b0, 1'b0, 3'd0, 8'h0, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: got hang expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) mpage[i] = 8'h00;
        repeat (3) @(negedge clk);
        e_vld = 0; e_addr = 0; e_be = 0; e_wrap = 0;
        check_out("R1 outputs in reset");
        rst = 1'b0;
        @(negedge clk);
        check_out("R1 outputs after reset");

        // R1: pages start at zero
        cycle(1, 3'd1, 16'h1234, 0, 0, 0, 0, "R1 page zero byte");
        cycle(1, 3'd6, 16'hABCD, 0, 0, 0, 0, "R1 page zero word");
        idle("R2 idle returns zero");

        // R6 / R3 / R5
        cycle(0, 0, 0, 0, 1, 3'd2, 8'h5A, "R6 write idle");
        cycle(1, 3'd2, 16'h00FF, 0, 0, 0, 0, "R3 R5 byte high lane");
        cycle(1, 3'd2, 16'h0100, 0, 0, 0, 0, "R5 byte low lane");
        cycle(1, 3'd2, 16'h4444, 0, 1, 3'd2, 8'h33, "R6 same cycle sees old page");
        cycle(1, 3'd2, 16'h4444, 0, 0, 0, 0, "R6 next cycle sees new page");

        // R7: cascade channel
        cycle(0, 0, 0, 0, 1, 3'd4, 8'h77, "R7 write cascade");
        cycle(1, 3'd4, 16'h0010, 0, 0, 0, 0, "R7 cascade page zero");

        // R4: word channel with page bit 0 set
        cycle(0, 0, 0, 0, 1, 3'd5, 8'hAB, "R4 write word page");
        cycle(1, 3'd5, 16'h8001, 0, 0, 0, 0, "R4 word mapping");
        cycle(1, 3'd5, 16'hFFFF, 0, 0, 0, 0, "R4 R8 word wrap top");

        // R9: isolation
        cycle(0, 0, 0, 0, 1, 3'd6, 8'hC3, "R9 write ch6");
        cycle(1, 3'd7, 16'h2222, 0, 0, 0, 0, "R9 ch7 unchanged");
        cycle(1, 3'd6, 16'h2222, 0, 0, 0, 0, "R9 ch6 updated");

        // R8: wrap flag
        cycle(0, 0, 0, 0, 1, 3'd0, 8'hF1, "R8 write ch0");
        cycle(1, 3'd0, 16'hFFFF, 0, 0, 0, 0, "R8 up at top");
        cycle(1, 3'd0, 16'h0000, 1, 0, 0, 0, "R8 down at bottom");
        cycle(1, 3'd0, 16'hFFFF, 1, 0, 0, 0, "R8 down at top");
        cycle(1, 3'd0, 16'h0000, 0, 0, 0, 0, "R8 up at bottom");
        idle("R2 idle after wrap");

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            logic [2:0]  c;
            logic [15:0] k;
            logic [3:0]  sel;
            c   = 3'($urandom);
            sel = 4'($urandom);
            k   = (sel == 0) ? 16'hFFFF : (sel == 1) ? 16'h0000 : 16'($urandom);
            cycle(($urandom % 5) != 0, c, k, 1'($urandom),
                  ($urandom % 4) == 0, 3'($urandom), 8'($urandom),
                  (c == 3'd4) ? "R7 random" : (c > 3'd4) ? "R4 random" : "R3 random");
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4415));
    end

endmodule